// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous serial slave that lets a host read and write a 128-entry register map of 16-bit words. The whole block is clocked by the host's serial clock `sclk`. Input data is sampled on rising edges, and only while the active-low select `cs_n` is low. Each transfer begins with an 8-bit header. The first header bit is the direction: 1 means read, 0 means write. The remaining seven bits are the start address, most significant bit first. One or more 16-bit data words follow, also most significant bit first. After each completed word the address steps by one, and it wraps from 7Fh back to 00h, so a long burst walks through the map.

The register storage is inside the block. A write word is committed only on the 16th rising edge of that word. If select is raised earlier, the word is thrown away. Read data leaves on `sdo` with an output enable `sdo_oe`; an external pad turns that pair into a tri-state line. The static input `late_mode` picks the launch edge:

- **Normal mode:** bits are launched on falling edges. A one-word read takes 24 clocks.
- **Delayed mode:** bits are launched on rising edges, half a clock later than normal mode, for fast clocks. A one-word read takes 25 clocks.

The sequencer has four states:

- **ST_IDLE:** entered on any edge that sees `cs_n` high, from every state. It also clears the bit counter.
- **ST_CMD:** ST_IDLE goes to ST_CMD on the first selected edge, which captures the direction bit.
- **ST_WRITE or ST_READ:** ST_CMD goes to one of these on the 8th header edge, as the direction bit chooses.
- **Word boundary:** ST_WRITE and ST_READ stay in their own state from word to word. At each boundary the counter returns to zero and the address steps by one.

Top module: `regmap_serial_port`

## Requirements
- R1: After `rst_n` is low, every register reads 0000h and `sdo_oe` is 0.
- R2: The first 8 selected rising edges carry the direction bit (1 = read, 0 = write) and then address bits 6 down to 0. The addressed register is the one accessed, and no other register is.
- R3: A write word is taken most significant bit first and is stored into the addressed register on its 16th rising edge.
- R4: After each completed data word the address advances by one, in both read and write bursts.
- R5: A burst word that follows the word at address 7Fh goes to address 00h.
- R6: When `cs_n` rises before the 16th edge of a write word, that word is discarded and the register keeps its old value. Earlier complete words in the burst stay written.
- R7: With `late_mode` = 0, bit b of read word w (w from 0) is valid for the host's rising edge number 9 + 16w + (15 − b), counted from select fall. A one-word read therefore takes 24 clocks.
- R8: With `late_mode` = 1, the same bit is valid for rising edge 10 + 16w + (15 − b), because it is launched on the rising edge before. A one-word read therefore takes 25 clocks.
- R9: Raising `cs_n` clears the transfer at once: `sdo_oe` drops to 0 while select is high, and the next transfer starts again with a fresh header.
- R10: Serial clock edges with `cs_n` high change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the host; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select, sampled on rising edges |
| sdi | input | 1 | Serial data from the host, sampled on rising edges |
| late_mode | input | 1 | 0 = launch read bits on falling edges, 1 = launch them on rising edges |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for `sdo`; 0 means the line is released |

## Verification
A write becomes visible on the 16th rising edge of its word. The bench therefore reads it back only in a later transfer, after select has gone high and low again. Read bits are due on the edge numbers given in R7 and R8. The bench samples `sdo` one nanosecond before each rising edge and files the bit under that edge's slot, so a launch that comes a cycle early or late corrupts the compared word. The release of `sdo_oe` follows `cs_n` combinationally and is checked half a nanosecond after select rises. Directed cases cover the wrap at 7Fh, partial words and out-of-transfer noise. A seeded random run of mixed transfers is compared with a bench register model.

// File: rtl/regmap_port_pkg.sv
package regmap_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WRITE = 2'd2,
        ST_READ  = 2'd3
    } seq_state_t;

    function automatic int cnt_width(input int addr_w, input int data_w);
        int longest;
        longest = (data_w > addr_w + 1) ? data_w : addr_w + 1;
        return $clog2(longest);
    endfunction

endpackage

// File: rtl/regmap_seq.sv
module regmap_seq
    import regmap_port_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    localparam int CNT_W = cnt_width(ADDR_W, DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sdi,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              wr_en,
    output logic [DATA_W-1:0] wdata,
    output logic              rd_active
);

    localparam int HDR_BITS = ADDR_W + 1;

    seq_state_t          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [ADDR_W-1:0]   addr_q, addr_d;
    logic [DATA_W-2:0]   shift_q, shift_d;
    logic                word_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
            shift_q <= shift_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        addr_d    = addr_q;
        shift_d   = {shift_q[DATA_W-3:0], sdi};
        wr_en     = 1'b0;
        word_done = 1'b0;
        if (cs_n) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_CMD;
                    cnt_d   = CNT_W'(1);
                end
                ST_CMD: begin
                    if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
                        state_d = shift_q[ADDR_W-1] ? ST_READ : ST_WRITE;
                        addr_d  = {shift_q[ADDR_W-2:0], sdi};
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_WRITE, ST_READ: begin
                    if (cnt_q == CNT_W'(DATA_W - 1)) begin
                        cnt_d     = '0;
                        addr_d    = addr_q + 1'b1;
                        word_done = 1'b1;
                        wr_en     = (state_q == ST_WRITE);
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign addr      = addr_q;
    assign bit_cnt   = cnt_q;
    assign wdata     = {shift_q, sdi};
    assign rd_active = (state_q == ST_READ);

    AST_IDLE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state_q == ST_IDLE && cnt_q == '0)); // R9

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> addr_q == ADDR_W'($past(addr_q) + 1'b1)); // R4

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && addr_q == '1) |=> addr_q == '0); // R5

endmodule

// File: rtl/regmap_bank.sv
module regmap_bank #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    AST_WR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(waddr)] == $past(wdata)); // R3

endmodule

// File: rtl/regmap_launch.sv
module regmap_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic late_mode,
    input  logic bit_in,
    input  logic rd_active,
    output logic sdo,
    output logic sdo_oe
);

    logic fall_q;
    logic rise_q;

    // normal timing: launched on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= bit_in;
        end
    end

    // delayed timing: launched half a clock later, on the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
        end else begin
            rise_q <= bit_in;
        end
    end

    assign sdo    = late_mode ? rise_q : fall_q;
    assign sdo_oe = !cs_n && rd_active;

    AST_LATE_HALF_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && !cs_n) |=> rise_q == $past(fall_q)); // R8

endmodule

// File: rtl/regmap_serial_port.sv
module regmap_serial_port
    import regmap_port_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sdi,
    input  logic late_mode,
    output logic sdo,
    output logic sdo_oe
);

    localparam int CNT_W = cnt_width(ADDR_W, DATA_W);

    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  bit_cnt;
    logic              wr_en;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              rd_active;
    logic              rd_bit;

    regmap_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (sclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .addr      (addr),
        .bit_cnt   (bit_cnt),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .rd_active (rd_active)
    );

    regmap_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk   (sclk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .waddr (addr),
        .wdata (wdata),
        .raddr (addr),
        .rdata (rdata)
    );

    assign rd_bit = rdata[CNT_W'(DATA_W - 1) - bit_cnt];

    regmap_launch u_launch (
        .clk       (sclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .late_mode (late_mode),
        .bit_in    (rd_bit),
        .rd_active (rd_active),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    AST_NO_WRITE_DESELECTED: assert property (@(posedge sclk) disable iff (!rst_n)
        wr_en |-> !cs_n); // R10

endmodule

// File: tb/regmap_serial_port_test.sv
`timescale 1ns/100ps
module regmap_serial_port_test;

    logic sclk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic late_mode = 1'b0;
    logic sdo;
    logic sdo_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] model [128];
    logic [15:0] wbuf [8];
    logic [15:0] rbuf [8];
    logic oe_mid;
    logic oe_after;

    always #2 sclk = ~sclk;

    regmap_serial_port uut (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .late_mode (late_mode),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    function automatic int first_data_edge(input bit late);
        return late ? 10 : 9;
    endfunction

    function automatic int edge_total(input bit late, input bit rd, input int nw, input int extra);
        return 8 + 16 * nw + ((rd && late) ? 1 : 0) + extra;
    endfunction

    task automatic check16(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check1(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic xfer(input bit late, input bit rd, input logic [6:0] a, input int nw, input int extra);
        int total;
        total = edge_total(late, rd, nw, extra);
        late_mode = late;
        for (int e = 1; e <= total; e++) begin
            @(negedge sclk);
            #1;
            cs_n = 1'b0;
            if (rd) begin
                int s;
                s = e - first_data_edge(late);
                if (s >= 0 && s / 16 < nw) rbuf[s / 16][15 - (s % 16)] = sdo;
                if (e == total) oe_mid = sdo_oe;
            end
            if (e <= 8) begin
                sdi = (e == 1) ? rd : a[8 - e];
            end else begin
                int idx;
                idx = e - 9;
                if (!rd && idx / 16 < nw) sdi = wbuf[idx / 16][15 - (idx % 16)];
                else sdi = 1'($urandom);
            end
        end
        @(negedge sclk);
        #1;
        cs_n = 1'b1;
        sdi = 1'($urandom);
        #0.5;
        oe_after = sdo_oe;
        if (!rd) begin
            for (int w = 0; w < nw; w++) model[a + 7'(w)] = wbuf[w];
        end
    endtask

    task automatic write_words(input bit late, input logic [6:0] a, input int nw, input int extra);
        xfer(late, 1'b0, a, nw, extra);
    endtask

    task automatic read_check(input string req, input bit late, input logic [6:0] a, input int nw);
        xfer(late, 1'b1, a, nw, 0);
        for (int w = 0; w < nw; w++) begin
            check16(req, $sformatf("read addr %h", a + 7'(w)), rbuf[w], model[a + 7'(w)]);
        end
        check1(req, "sdo_oe during read", oe_mid, 1'b1);
        check1("R9", "sdo_oe after select rise", oe_after, 1'b0);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd7741);
        for (int i = 0; i < 128; i++) model[i] = 16'h0000;
        repeat (3) @(negedge sclk);
        #1;
        check1("R1", "sdo_oe in reset", sdo_oe, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge sclk);
        #1;
        check1("R1", "sdo_oe after reset", sdo_oe, 1'b0);
        read_check("R1", 1'b0, 7'h7D, 4);
        read_check("R1", 1'b1, 7'h40, 2);

        // R3: single word write, normal read back
        wbuf[0] = 16'hA5C3;
        write_words(1'b0, 7'h10, 1, 0);
        read_check("R3", 1'b0, 7'h10, 1);

        // R2: address order; 0Bh bit-reversed is 68h
        wbuf[0] = 16'h1E2D;
        write_words(1'b0, 7'h0B, 1, 0);
        read_check("R2", 1'b0, 7'h68, 1);
        read_check("R2", 1'b0, 7'h0B, 1);

        // R4 R5: burst across the top of the map
        wbuf[0] = 16'h7E7E; wbuf[1] = 16'h7F7F; wbuf[2] = 16'h0A0A; wbuf[3] = 16'h0101;
        write_words(1'b0, 7'h7E, 4, 0);
        read_check("R5", 1'b0, 7'h00, 2);
        read_check("R4", 1'b0, 7'h7E, 4);
        read_check("R8", 1'b1, 7'h7E, 4);
        read_check("R7", 1'b0, 7'h7F, 3);

        // R6: partial words dropped
        wbuf[0] = 16'hBEEF;
        write_words(1'b0, 7'h31, 1, 0);
        wbuf[0] = 16'h4321;
        write_words(1'b0, 7'h30, 1, 9);
        read_check("R6", 1'b0, 7'h30, 2);
        wbuf[0] = 16'h5A5A;
        write_words(1'b1, 7'h30, 1, 15);
        read_check("R6", 1'b1, 7'h30, 2);
        write_words(1'b0, 7'h31, 0, 12);
        read_check("R6", 1'b0, 7'h31, 1);

        // R9: aborted read, then a fresh header
        xfer(1'b0, 1'b1, 7'h10, 0, 7);
        check1("R9", "sdo_oe after aborted read", oe_after, 1'b0);
        wbuf[0] = 16'hC0DE;
        write_words(1'b0, 7'h22, 1, 0);
        read_check("R9", 1'b0, 7'h22, 1);

        // R10: clock and data noise while deselected
        late_mode = 1'b0;
        for (int k = 0; k < 48; k++) begin
            @(negedge sclk);
            #1;
            sdi = 1'($urandom);
            if (k == 20) check1("R10", "sdo_oe while deselected", sdo_oe, 1'b0);
        end
        read_check("R10", 1'b0, 7'h10, 1);
        read_check("R10", 1'b0, 7'h22, 1);

        // random mix
        for (int t = 0; t < 40; t++) begin
            bit late;
            bit rd;
            logic [6:0] a;
            int nw;
            late = 1'($urandom);
            rd = 1'($urandom);
            a = 7'($urandom);
            nw = 1 + int'($urandom % 4);
            if (rd) begin
                read_check(late ? "R8" : "R7", late, a, nw);
            end else begin
                for (int w = 0; w < nw; w++) wbuf[w] = 16'($urandom);
                write_words(late, a, nw, 0);
                read_check("R4", late, a, nw);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule